// File: doc/BRIEF.md
# Bit-Serial Fixed-Point Processing Element

This block is one processing element whose arithmetic runs through a single one-bit full adder with a carry flip-flop. Its operands are fixed-point words held one bit per address in an external bit-addressed local memory. Each operand is a run of consecutive addresses starting at a base address, and bit i of a word sits at base + i. The element performs either an addition C = A + B or a multiply-accumulate C = C + A*B. Every operand of one operation has the same width b, and that width is chosen at run time for each operation.

A caller places the operands in memory, sets the operation, the three base addresses and the width, and pulses start. The element then streams bits least significant first through its adder, one bit per clock. It reads the memory through an asynchronous read port and writes result bits through a separate synchronous write port. An addition takes 2b cycles. A multiply-accumulate takes 2b² cycles, because it makes one shift-and-add pass over the accumulator for each multiplier bit. A done pulse marks the last cycle of the operation.

Top module: `bitser_pe`

## Requirements
- R1: With op_sel = 0, an accepted start makes C (b bits at c_base) equal (A + B) mod 2^b. A is read at a_base and B at b_base, both b-bit two's complement with bit i at base + i, and overflow wraps.
- R2: With op_sel = 1, an accepted start makes C equal (C + A*B) mod 2^b in two's complement. The carry out of the top bit and all product bits above b are dropped.
- R3: After a start accepted in cycle t for an addition, done is high in cycle t + 2b and in no other cycle, for exactly one cycle.
- R4: After a start accepted in cycle t for a multiply-accumulate, done is high in cycle t + 2b² and in no other cycle, for exactly one cycle.
- R5: A start pulse while an operation is running, including in the cycle done is high, is ignored. The running operation keeps its inputs, timing and result, and the second request writes nothing.
- R6: An operation writes only the addresses c_base .. c_base + b - 1. The memory just below and just above that range is left unchanged.
- R7: The width input is clamped: values below 2 act as b = 2, and values above MAXW act as b = MAXW.
- R8: During and after reset, until a start is accepted, done is low and no memory write is issued.
- R9: An addition may place C at the same base as A or as B. The in-place result is still (A + B) mod 2^b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request, accepted only when idle |
| op_sel | input | 1 | 0 = add, 1 = multiply-accumulate |
| width_sel | input | WW | Operand width b (clamped to 2..MAXW) |
| a_base | input | AW | Bit address of A's least significant bit |
| b_base | input | AW | Bit address of B's least significant bit |
| c_base | input | AW | Bit address of C's least significant bit |
| done | output | 1 | One-cycle pulse in the final cycle of an operation |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_bit | input | 1 | Memory read data, returned in the same cycle |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_bit | output | 1 | Memory write data |

## Verification
The bench builds the element with its defaults: MAXW = 16, AW = 10 and a 5-bit width input. These values let it drive widths from 0 to 31. The out-of-range values exercise both clamp bounds, and the largest legal width runs a 512-cycle multiply-accumulate. The 1024-bit memory holds the operands, the result, guard words on each side of the result, and a separate region that an ignored request would target if it were wrongly accepted. The bench also covers the smallest width, b = 2. At that width the multiplier-bit prefetch depends on there being only one earlier pass, and sign wrap occurs with just two bits.

// File: rtl/pe_pkg.sv
// Shared types for the bit-serial processing element.
package pe_pkg;

    // Operation codes; the encoding equals the op_sel pin value.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MAC = 1'b1
    } pe_op_e;

endpackage

// File: rtl/pe_fa.sv
// One-bit full adder: the only arithmetic element of the processing element.
// Assumes nothing; purely combinational.
module pe_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    // Sum and majority carry.
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end

endmodule

// File: rtl/pe_seq.sv
// Sequencer: accepts a start when idle, clamps the width and walks the
// pass index j, the bit index k and the phase ph. An add is one pass with
// j = 0. A multiply-accumulate makes passes j = b-1 down to 0, each of
// b bit pairs of two cycles. Assumes the width input is held only at start.
module pe_seq
    import pe_pkg::*;
#(
    parameter int MAXW = 16,
    parameter int WW   = $clog2(MAXW + 1),
    parameter int IW   = $clog2(MAXW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  pe_op_e        op_in,
    input  logic [WW-1:0] wid,
    output logic          busy,
    output pe_op_e        op,
    output logic [IW-1:0] j,
    output logic [IW-1:0] k,
    output logic          ph,
    output logic          accept,
    output logic          pass_end,
    output logic          last
);

    localparam logic [WW-1:0] W_MIN = WW'(2);
    localparam logic [WW-1:0] W_MAX = WW'(MAXW);
    localparam logic [WW-1:0] W_ONE = WW'(1);

    logic [WW-1:0] wid_c;
    logic [WW-1:0] bw;
    logic          pair_last;

    // Clamp the requested width into the supported range.
    always_comb begin
        if (wid < W_MIN)      wid_c = W_MIN;
        else if (wid > W_MAX) wid_c = W_MAX;
        else                  wid_c = wid;
    end

    // Decode the end of a bit pair, of a pass and of the operation.
    always_comb begin
        accept    = start && !busy;
        pair_last = (WW'(k) == (bw - W_ONE));
        pass_end  = busy && ph && pair_last;
        last      = pass_end && (j == '0);
    end

    // Step the counters one cycle at a time while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            op   <= OP_ADD;
            bw   <= W_MIN;
            j    <= '0;
            k    <= '0;
            ph   <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                op   <= op_in;
                bw   <= wid_c;
                j    <= (op_in == OP_MAC) ? IW'(wid_c - W_ONE) : '0;
                k    <= '0;
                ph   <= 1'b0;
            end
        end else begin
            ph <= ~ph;
            if (ph) begin
                if (pair_last) begin
                    k <= '0;
                    if (j == '0) busy <= 1'b0;
                    else         j    <= j - IW'(1);
                end else begin
                    k <= k + IW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pe_agen.sv
// Address generator. A bit pair k is active when k >= j. In phase 0 it
// reads the multiplicand bit A[k-j]. In phase 1 it reads the accumulator
// bit (B for add, C for MAC) and writes C[k]. In the idle pair 0 of a MAC
// pass j >= 1, phase 0 fetches multiplier bit B[j]. In pass 1, phase 1
// also prefetches B[0] for the final pass, which has no idle pair.
module pe_agen
    import pe_pkg::*;
#(
    parameter int AW = 10,
    parameter int IW = 4
) (
    input  logic          busy,
    input  pe_op_e        op,
    input  logic [IW-1:0] j,
    input  logic [IW-1:0] k,
    input  logic          ph,
    input  logic [AW-1:0] a_q,
    input  logic [AW-1:0] b_q,
    input  logic [AW-1:0] c_q,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          active,
    output logic          fetch_m,
    output logic          fetch_n
);

    logic idle_pair0;

    // Classify the current cycle.
    always_comb begin
        active     = busy && (k >= j);
        idle_pair0 = busy && (op == OP_MAC) && (j != '0) && (k == '0);
        fetch_m    = idle_pair0 && !ph;
        fetch_n    = idle_pair0 && ph && (j == IW'(1));
    end

    // Select the read address for this cycle.
    always_comb begin
        if (active && !ph)
            rd_addr = a_q + AW'(k - j);
        else if (active)
            rd_addr = ((op == OP_ADD) ? b_q : c_q) + AW'(k);
        else if (fetch_m)
            rd_addr = b_q + AW'(j);
        else if (fetch_n)
            rd_addr = b_q + AW'(j - IW'(1));
        else
            rd_addr = a_q;
    end

    // The result bit always lands at position k of C.
    always_comb wr_addr = c_q + AW'(k);

endmodule

// File: rtl/pe_alu.sv
// Bit datapath: multiplicand-bit latch, two multiplier-bit latches, the
// carry flip-flop and the full adder. The addend is the multiplicand bit
// gated by the multiplier bit (forced to 1 for add). The carry clears at
// the end of every pass and while idle.
module pe_alu (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_carry,
    input  logic cap_a,
    input  logic cap_m,
    input  logic cap_n,
    input  logic add_en,
    input  logic is_add,
    input  logic use_n,
    input  logic rd_bit,
    output logic wr_bit
);

    logic abit, mb, nb, carry, mult, addend, cout;

    // Capture operand bits fetched from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abit <= 1'b0;
            mb   <= 1'b0;
            nb   <= 1'b0;
        end else begin
            if (cap_a) abit <= rd_bit;
            if (cap_m) mb   <= rd_bit;
            if (cap_n) nb   <= rd_bit;
        end
    end

    // Carry flip-flop: cleared between passes, updated on each add step.
    always_ff @(posedge clk) begin
        if (!rst_n)         carry <= 1'b0;
        else if (clr_carry) carry <= 1'b0;
        else if (add_en)    carry <= cout;
    end

    // Gate the multiplicand bit with the active multiplier bit.
    always_comb begin
        mult   = is_add ? 1'b1 : (use_n ? nb : mb);
        addend = abit & mult;
    end

    pe_fa u_fa (
        .a  (addend),
        .b  (rd_bit),
        .ci (carry),
        .s  (wr_bit),
        .co (cout)
    );

endmodule

// File: rtl/bitser_pe.sv
// Bit-serial processing element, top level. Runs add (C = A + B) or
// multiply-accumulate (C = C + A*B) on b-bit two's complement words stored
// one bit per address, least significant bit at the base. Assumes the
// memory read is combinational, the write is synchronous, and for MAC the
// C range does not overlap A or B.
module bitser_pe
    import pe_pkg::*;
#(
    parameter int MAXW = 16,
    parameter int AW   = 10,
    parameter int WW   = $clog2(MAXW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_sel,
    input  logic [WW-1:0] width_sel,
    input  logic [AW-1:0] a_base,
    input  logic [AW-1:0] b_base,
    input  logic [AW-1:0] c_base,
    output logic          done,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_bit,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic          mem_wr_bit
);

    localparam int IW = (MAXW > 2) ? $clog2(MAXW) : 1;

    pe_op_e        op_in, op_q;
    logic          busy, ph, accept, pass_end, last;
    logic          active, fetch_m, fetch_n;
    logic [IW-1:0] j, k;
    logic [AW-1:0] a_q, b_q, c_q;

    assign op_in = pe_op_e'(op_sel);

    // Hold the operand bases for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= '0;
        end else if (accept) begin
            a_q <= a_base;
            b_q <= b_base;
            c_q <= c_base;
        end
    end

    pe_seq #(.MAXW(MAXW), .WW(WW), .IW(IW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_in    (op_in),
        .wid      (width_sel),
        .busy     (busy),
        .op       (op_q),
        .j        (j),
        .k        (k),
        .ph       (ph),
        .accept   (accept),
        .pass_end (pass_end),
        .last     (last)
    );

    pe_agen #(.AW(AW), .IW(IW)) u_agen (
        .busy    (busy),
        .op      (op_q),
        .j       (j),
        .k       (k),
        .ph      (ph),
        .a_q     (a_q),
        .b_q     (b_q),
        .c_q     (c_q),
        .rd_addr (mem_rd_addr),
        .wr_addr (mem_wr_addr),
        .active  (active),
        .fetch_m (fetch_m),
        .fetch_n (fetch_n)
    );

    pe_alu u_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_carry (pass_end || !busy),
        .cap_a     (active && !ph),
        .cap_m     (fetch_m),
        .cap_n     (fetch_n),
        .add_en    (active && ph),
        .is_add    (op_q == OP_ADD),
        .use_n     ((op_q == OP_MAC) && (j == '0)),
        .rd_bit    (mem_rd_bit),
        .wr_bit    (mem_wr_bit)
    );

    // Result write and completion pulse.
    always_comb begin
        mem_wr_en = active && ph;
        done      = last;
    end

endmodule

// File: rtl/pe_chk.sv
// Checker for bitser_pe: keeps its own count of the cycles left after an
// accepted start and checks completion timing and write confinement.
module pe_chk #(
    parameter int MAXW = 16,
    parameter int AW   = 10,
    parameter int WW   = $clog2(MAXW + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op_sel,
    input logic [WW-1:0] width_sel,
    input logic [AW-1:0] c_base,
    input logic          done,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_wr_addr
);

    int unsigned   due;
    int            bwc;
    logic [AW-1:0] cb;
    logic [AW-1:0] wr_off;

    function automatic int clampw(input logic [WW-1:0] x);
        int v;
        v = int'(x);
        if (v < 2)    v = 2;
        if (v > MAXW) v = MAXW;
        return v;
    endfunction

    // Count down the expected operation length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due <= 0;
            bwc <= 2;
            cb  <= '0;
        end else if (due == 0) begin
            if (start) begin
                due <= op_sel ? 2 * clampw(width_sel) * clampw(width_sel)
                              : 2 * clampw(width_sel);
                bwc <= clampw(width_sel);
                cb  <= c_base;
            end
        end else begin
            due <= due - 1;
        end
    end

    // Offset of a write from the latched result base.
    always_comb wr_off = mem_wr_addr - cb;

    // R3, R4, R5: done arrives exactly when the count runs out.
    a_r3_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        (due == 1) |-> done);
    a_r4_done_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (due == 1));
    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_write_in_c: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (int'(wr_off) < bwc));
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (due == 0) |-> (!mem_wr_en && !done));

endmodule

bind bitser_pe pe_chk #(.MAXW(MAXW), .AW(AW), .WW(WW)) u_pe_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_sel      (op_sel),
    .width_sel   (width_sel),
    .c_base      (c_base),
    .done        (done),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr)
);

// File: tb/tb_bitser_pe.sv
`timescale 1ns/1ps
module tb_bitser_pe;

    localparam int MAXW  = 16;
    localparam int AW    = 10;
    localparam int WW    = $clog2(MAXW + 1);
    localparam int DEPTH = 1 << AW;
    localparam int ABASE = 0;
    localparam int BBASE = 64;
    localparam int CBASE = 128;
    localparam int DBASE = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_sel = 1'b0;
    logic [WW-1:0] width_sel = '0;
    logic [AW-1:0] a_base = '0, b_base = '0, c_base = '0;
    logic          done, mem_rd_bit, mem_wr_en, mem_wr_bit;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;

    logic          mem [DEPTH];
    int            checks = 0, errors = 0, cyc = 0;
    int            mcnt = 0, mbw = 2;
    logic [AW-1:0] mcb = '0;
    bit            finished = 0;

    always #2 clk = ~clk;

    bitser_pe #(.MAXW(MAXW), .AW(AW), .WW(WW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .width_sel(width_sel), .a_base(a_base), .b_base(b_base),
        .c_base(c_base), .done(done), .mem_rd_addr(mem_rd_addr),
        .mem_rd_bit(mem_rd_bit), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_bit(mem_wr_bit)
    );

    assign mem_rd_bit = mem[mem_rd_addr];

    function automatic int clampw(input int x);
        if (x < 2)    return 2;
        if (x > MAXW) return MAXW;
        return x;
    endfunction

    // Memory model and reference countdown of the operation.
    always @(posedge clk) begin
        int w;
        cyc <= cyc + 1;
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_bit;
        if (!rst_n) mcnt <= 0;
        else if (mcnt == 0) begin
            if (start) begin
                w = clampw(int'(width_sel));
                mcnt <= op_sel ? 2 * w * w : 2 * w;
                mbw  <= w;
                mcb  <= c_base;
            end
        end else mcnt <= mcnt - 1;
    end

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        logic [AW-1:0] off;
        if (rst_n && !finished) begin
            checks++;
            if (done !== (mcnt == 1)) begin
                errors++;
                $display("FAIL R3/R4 done timing at cycle %0d: actual %0b expected %0b",
                         cyc, done, (mcnt == 1));
            end
            if (mem_wr_en === 1'b1) begin
                off = mem_wr_addr - mcb;
                if (mcnt == 0) begin
                    errors++;
                    $display("FAIL R8 write while idle: actual addr %0d expected none", mem_wr_addr);
                end else if (int'(off) >= mbw) begin
                    errors++;
                    $display("FAIL R6 write outside C: actual offset %0d expected < %0d", off, mbw);
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int base, input int w, input longint v);
        for (int i = 0; i < w; i++) mem[(base + i) % DEPTH] = v[i];
    endtask

    function automatic longint get(input int base, input int w);
        longint r = 0;
        for (int i = 0; i < w; i++)
            if (mem[(base + i) % DEPTH] === 1'b1) r |= (longint'(1) << i);
        return r;
    endfunction

    // Pulse start for one cycle; returns the cycle number of the start cycle.
    task automatic launch(input bit op, input int wid, input int ab, input int bb,
                          input int cb, output int s);
        @(negedge clk);
        op_sel = op; width_sel = WW'(wid);
        a_base = AW'(ab); b_base = AW'(bb); c_base = AW'(cb);
        start = 1'b1; s = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int d);
        int n = 0;
        while (done !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) begin
            errors++;
            $display("FAIL R3/R4 no done: actual none expected pulse");
        end
        d = cyc;
    endtask

    task automatic run_case(input string rr, input string rt, input bit op, input int wid,
                            input longint av, input longint bv, input longint cv);
        int w, s, d;
        longint m, exp;
        w = clampw(wid);
        m = (longint'(1) << w) - 1;
        exp = op ? ((cv + av * bv) & m) : ((av + bv) & m);
        put(ABASE, w, av); put(BBASE, w, bv);
        put(CBASE, w, op ? cv : 64'h5A5A);
        put(CBASE - 8, 8, 8'hC3); put(CBASE + w, 8, 8'hA5);
        launch(op, wid, ABASE, BBASE, CBASE, s);
        wait_done(d);
        chk(rt, "cycles to done", d - s, op ? 2 * w * w : 2 * w);
        @(negedge clk);
        chk(rr, "result", get(CBASE, w), exp);
        chk("R6", "guard below C", get(CBASE - 8, 8), 8'hC3);
        chk("R6", "guard above C", get(CBASE + w, 8), 8'hA5);
    endtask

    initial begin
        int s, d, late;
        for (int i = 0; i < DEPTH; i++) mem[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "done in reset", longint'(done), 0);
        chk("R8", "write in reset", longint'(mem_wr_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "done after reset", longint'(done), 0);
        chk("R8", "write after reset", longint'(mem_wr_en), 0);

        // R1 / R3: additions at several widths and patterns.
        run_case("R1", "R3", 0, 8, 100, 27, 0);
        run_case("R1", "R3", 0, 8, 127, 1, 0);
        run_case("R1", "R3", 0, 8, 255, 255, 0);
        run_case("R1", "R3", 0, 8, 200, 100, 0);
        run_case("R1", "R3", 0, 2, 3, 2, 0);
        run_case("R1", "R3", 0, 16, 40000, 30000, 0);
        // R2 / R4: multiply-accumulate including negative and wrapping cases.
        run_case("R2", "R4", 1, 8, 3, 7, 5);
        run_case("R2", "R4", 1, 8, 253, 5, 10);
        run_case("R2", "R4", 1, 8, 16, 16, 0);
        run_case("R2", "R4", 1, 2, 3, 3, 1);
        run_case("R2", "R4", 1, 3, 5, 6, 7);
        run_case("R2", "R4", 1, 16, 300, 65534, 1000);
        // R7: width clamping at both ends.
        run_case("R7", "R7", 0, 0, 3, 3, 0);
        run_case("R7", "R7", 1, 1, 2, 3, 1);
        run_case("R7", "R7", 0, 31, 65535, 2, 0);

        // R9: in-place add, C over A then C over B.
        put(CBASE, 8, 90); put(BBASE, 8, 40);
        launch(0, 8, CBASE, BBASE, CBASE, s); wait_done(d); @(negedge clk);
        chk("R9", "C over A", get(CBASE, 8), 130);
        put(ABASE, 8, 200); put(CBASE, 8, 100);
        launch(0, 8, ABASE, CBASE, CBASE, s); wait_done(d); @(negedge clk);
        chk("R9", "C over B", get(CBASE, 8), 44);

        // R5: starts while running and in the done cycle are ignored.
        put(ABASE, 8, 3); put(BBASE, 8, 7); put(CBASE, 8, 5);
        put(DBASE, 16, 16'hFFFF);
        launch(1, 8, ABASE, BBASE, CBASE, s);
        repeat (10) @(negedge clk);
        op_sel = 1'b0; width_sel = WW'(4); c_base = AW'(DBASE); a_base = AW'(BBASE);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(d);
        chk("R5", "cycles with busy start", d - s, 128);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R5", "result kept", get(CBASE, 8), 26);
        late = 0;
        repeat (20) begin @(negedge clk); if (done === 1'b1) late++; end
        chk("R5", "no done from ignored start", late, 0);
        chk("R5", "ignored target untouched", get(DBASE, 16), 16'hFFFF);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule